// File: doc/BRIEF.md
# Address-Window Endian Swapper

This stage sits between a big-endian master port and a little-endian slave port, both 32 bits wide, and presents one target region under three aliased address windows. Two address bits just above the region decide, per access, how the four byte lanes of the data are rearranged. The three options are pass-through, exchange of the two halfwords, and full reversal of the byte lanes. Software picks the conversion that fits the data type it moves by addressing the matching alias.

Write data and write strobes are rearranged on the way out. The conversion chosen by each accepted request is held until its response returns, and the read data is rearranged the same way on the way back. The window bits are cleared before the address reaches the slave, so all aliases hit the same physical locations. The rest of the address is never reordered.

Requests and responses use a single-beat valid/ready handshake. Valid and ready pass straight through with no added cycle, and at most one transaction is outstanding.

Top module: `addr_window_swapper`

## Requirements
- R1: Address bits [WIN_LSB+1:WIN_LSB] select the mode: 0 selects pass-through, 1 selects halfword exchange, 2 selects byte reversal, and 3 selects pass-through with `win_err` high. `win_err` is low for the other three codes.
- R2: In pass-through mode, the write data on the slave side equals the write data on the master side.
- R3: In halfword mode, slave write data is {wdata[15:0], wdata[31:16]}.
- R4: In byte-reversal mode, slave write data is {wdata[7:0], wdata[15:8], wdata[23:16], wdata[31:24]}.
- R5: Strobe bit i describes byte lane i (bits 8i+7..8i). The 4-bit strobe is permuted with the same lane mapping as the data: identity, {s[1:0],s[3:2]}, or {s[0],s[1],s[2],s[3]}.
- R6: The slave address equals the master address with the two window bits forced to zero. All other bits are unchanged and in place.
- R7: Read data returned on the master side is permuted with the mode of the request that was accepted before it.
- R8: When idle, `s_req_valid` follows `m_req_valid` and `m_req_ready` follows `s_req_ready` in the same cycle. `s_req_write` equals `m_req_write`.
- R9: While a transaction is outstanding and its response is not completing, `s_req_valid` and `m_req_ready` are low.
- R10: A new request can be accepted in the cycle in which the outstanding response completes. That response still uses the old mode, and the next response uses the new request's mode.
- R11: After reset no transaction is outstanding, the stored mode is pass-through, and a request is passed through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| m_req_valid | input | 1 | Master request valid |
| m_req_ready | output | 1 | Master request ready |
| m_req_write | input | 1 | 1 = write, 0 = read |
| m_req_addr | input | ADDR_W | Master byte address including window bits |
| m_req_wdata | input | 32 | Master write data |
| m_req_wstrb | input | 4 | Master write strobes, bit i for lane i |
| m_rsp_valid | output | 1 | Response valid toward master |
| m_rsp_ready | input | 1 | Master accepts response |
| m_rsp_rdata | output | 32 | Permuted read data |
| s_req_valid | output | 1 | Slave request valid |
| s_req_ready | input | 1 | Slave request ready |
| s_req_write | output | 1 | Forwarded write flag |
| s_req_addr | output | ADDR_W | Address with window bits cleared |
| s_req_wdata | output | 32 | Permuted write data |
| s_req_wstrb | output | 4 | Permuted write strobes |
| s_rsp_valid | input | 1 | Slave response valid |
| s_rsp_ready | output | 1 | Ready toward slave response |
| s_rsp_rdata | input | 32 | Slave read data |
| win_err | output | 1 | Request addresses the unused window code |

## Verification
The case where the two functions meet is a response completing while a new request is accepted in the same cycle. The returning data must use the stored mode of the older request, while the mode register is being overwritten with the new request's window. The bench first accepts a read in the byte-reversal window. It then presents the slave response and a halfword-window request together, and checks that the returning word is byte-reversed and that the request is accepted. The following response must come back with its halfwords exchanged. In a variant, the master stalls the response, and the bench checks that the new request is then held off.

// File: rtl/endswap_pkg.sv
package endswap_pkg;

    typedef enum logic [1:0] {
        SWAP_NONE = 2'd0,
        SWAP_HALF = 2'd1,
        SWAP_BYTE = 2'd2
    } swap_mode_e;

    typedef struct packed {
        logic       busy;
        swap_mode_e mode;
    } swap_ctl_t;

endpackage

// File: rtl/win_decode.sv
module win_decode
    import endswap_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int WIN_LSB = 16
) (
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out,
    output swap_mode_e        mode,
    output logic              bad_win
);
    localparam logic [ADDR_W-1:0] WIN_MASK = {{(ADDR_W-2){1'b0}}, 2'b11} << WIN_LSB;

    logic [1:0] sel;

    always_comb begin
        sel      = addr_in[WIN_LSB+1:WIN_LSB];
        addr_out = addr_in & ~WIN_MASK;
        bad_win  = 1'b0;
        case (sel)
            2'd1:    mode = SWAP_HALF;
            2'd2:    mode = SWAP_BYTE;
            2'd3: begin
                mode    = SWAP_NONE;
                bad_win = 1'b1;
            end
            default: mode = SWAP_NONE;
        endcase
    end
endmodule

// File: rtl/lane_permute.sv
module lane_permute
    import endswap_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic [LANES*LANE_W-1:0] din,
    input  swap_mode_e              mode,
    output logic [LANES*LANE_W-1:0] dout
);
    localparam int HALF = LANES / 2;

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        localparam int SRC_HALF = j ^ HALF;
        localparam int SRC_BYTE = LANES - 1 - j;
        always_comb begin
            case (mode)
                SWAP_HALF: dout[j*LANE_W +: LANE_W] = din[SRC_HALF*LANE_W +: LANE_W];
                SWAP_BYTE: dout[j*LANE_W +: LANE_W] = din[SRC_BYTE*LANE_W +: LANE_W];
                default:   dout[j*LANE_W +: LANE_W] = din[j*LANE_W +: LANE_W];
            endcase
        end
    end
endmodule

// File: rtl/addr_window_swapper.sv
module addr_window_swapper
    import endswap_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int WIN_LSB = 16,
    parameter int DATA_W  = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                m_req_valid,
    output logic                m_req_ready,
    input  logic                m_req_write,
    input  logic [ADDR_W-1:0]   m_req_addr,
    input  logic [DATA_W-1:0]   m_req_wdata,
    input  logic [DATA_W/8-1:0] m_req_wstrb,
    output logic                m_rsp_valid,
    input  logic                m_rsp_ready,
    output logic [DATA_W-1:0]   m_rsp_rdata,
    output logic                s_req_valid,
    input  logic                s_req_ready,
    output logic                s_req_write,
    output logic [ADDR_W-1:0]   s_req_addr,
    output logic [DATA_W-1:0]   s_req_wdata,
    output logic [DATA_W/8-1:0] s_req_wstrb,
    input  logic                s_rsp_valid,
    output logic                s_rsp_ready,
    input  logic [DATA_W-1:0]   s_rsp_rdata,
    output logic                win_err
);
    localparam int LANES = DATA_W / 8;

    swap_ctl_t  ctl_d, ctl_q;
    swap_mode_e req_mode;
    logic       rsp_fire;
    logic       req_fire;
    logic       slot_free;

    win_decode #(.ADDR_W(ADDR_W), .WIN_LSB(WIN_LSB)) u_dec (
        .addr_in  (m_req_addr),
        .addr_out (s_req_addr),
        .mode     (req_mode),
        .bad_win  (win_err)
    );

    lane_permute #(.LANES(LANES), .LANE_W(8)) u_wdata (
        .din  (m_req_wdata),
        .mode (req_mode),
        .dout (s_req_wdata)
    );

    lane_permute #(.LANES(LANES), .LANE_W(1)) u_wstrb (
        .din  (m_req_wstrb),
        .mode (req_mode),
        .dout (s_req_wstrb)
    );

    lane_permute #(.LANES(LANES), .LANE_W(8)) u_rdata (
        .din  (s_rsp_rdata),
        .mode (ctl_q.mode),
        .dout (m_rsp_rdata)
    );

    always_comb begin
        rsp_fire    = s_rsp_valid & m_rsp_ready;
        slot_free   = ~ctl_q.busy | rsp_fire;
        s_req_valid = m_req_valid & slot_free;
        m_req_ready = s_req_ready & slot_free;
        s_req_write = m_req_write;
        m_rsp_valid = s_rsp_valid;
        s_rsp_ready = m_rsp_ready;
        req_fire    = m_req_valid & m_req_ready;

        ctl_d = ctl_q;
        if (rsp_fire) begin
            ctl_d.busy = 1'b0;
        end
        if (req_fire) begin
            ctl_d.busy = 1'b1;
            ctl_d.mode = req_mode;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{busy: 1'b0, mode: SWAP_NONE};
        end else begin
            ctl_q <= ctl_d;
        end
    end
endmodule

// File: rtl/addr_window_swapper_chk.sv
module addr_window_swapper_chk #(
    parameter int ADDR_W  = 32,
    parameter int WIN_LSB = 16,
    parameter int DATA_W  = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                m_req_valid,
    input logic [ADDR_W-1:0]   m_req_addr,
    input logic [DATA_W-1:0]   m_req_wdata,
    input logic [DATA_W/8-1:0] m_req_wstrb,
    input logic                s_req_valid,
    input logic                s_req_ready,
    input logic [ADDR_W-1:0]   s_req_addr,
    input logic [DATA_W-1:0]   s_req_wdata,
    input logic [DATA_W/8-1:0] s_req_wstrb,
    input logic                win_err,
    input logic                s_rsp_valid,
    input logic                s_rsp_ready,
    input logic [DATA_W-1:0]   s_rsp_rdata,
    input logic                m_rsp_valid,
    input logic [DATA_W-1:0]   m_rsp_rdata
);
    logic pending_q;
    logic s_fire;
    logic r_fire;

    assign s_fire = s_req_valid & s_req_ready;
    assign r_fire = s_rsp_valid & s_rsp_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      pending_q <= 1'b0;
        else if (s_fire) pending_q <= 1'b1;
        else if (r_fire) pending_q <= 1'b0;
    end

    p_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_q && s_fire) |-> r_fire);

    p_window_cleared_r6: assert property (@(posedge clk) disable iff (!rst_n)
        s_req_valid |-> (s_req_addr[WIN_LSB+1:WIN_LSB] == 2'b00));

    p_plain_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_req_valid && m_req_addr[WIN_LSB+1:WIN_LSB] == 2'b00) |-> (s_req_wdata == m_req_wdata));

    p_strobe_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
        s_req_valid |-> ($countones(s_req_wstrb) == $countones(m_req_wstrb)));

    p_rsp_bytes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        m_rsp_valid |-> ($countones(m_rsp_rdata) == $countones(s_rsp_rdata)));

    p_err_plain_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (win_err && s_req_valid) |-> (s_req_wdata == m_req_wdata));

    p_valid_path_r8: assert property (@(posedge clk) disable iff (!rst_n)
        s_req_valid |-> m_req_valid);
endmodule

bind addr_window_swapper addr_window_swapper_chk #(
    .ADDR_W (ADDR_W),
    .WIN_LSB(WIN_LSB),
    .DATA_W (DATA_W)
) u_chk (.*);

// File: tb/sim_addr_window_swapper.sv
module sim_addr_window_swapper;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_req_valid = 1'b0, m_req_write = 1'b0, m_rsp_ready = 1'b0;
    logic [31:0] m_req_addr = '0, m_req_wdata = '0;
    logic [3:0]  m_req_wstrb = '0;
    logic        s_req_ready = 1'b0, s_rsp_valid = 1'b0;
    logic [31:0] s_rsp_rdata = '0;
    logic        m_req_ready, m_rsp_valid, s_req_valid, s_req_write, s_rsp_ready, win_err;
    logic [31:0] m_rsp_rdata, s_req_addr, s_req_wdata;
    logic [3:0]  s_req_wstrb;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    addr_window_swapper u0 (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_data(input int w, input logic [31:0] d);
        case (w)
            1:       return {d[15:0], d[31:16]};
            2:       return {d[7:0], d[15:8], d[23:16], d[31:24]};
            default: return d;
        endcase
    endfunction

    function automatic logic [3:0] exp_strb(input int w, input logic [3:0] s);
        case (w)
            1:       return {s[1:0], s[3:2]};
            2:       return {s[0], s[1], s[2], s[3]};
            default: return s;
        endcase
    endfunction

    task automatic accept_read(input int w, input logic [31:0] off);
        @(negedge clk);
        m_req_valid = 1'b1; m_req_write = 1'b0; s_req_ready = 1'b1;
        m_req_addr = off | (32'(w) << 16);
        @(posedge clk);
    endtask

    task automatic finish_sim;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            finish_sim();
        end
    end

    initial begin
        // R11: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        s_rsp_valid = 1'b1; s_rsp_rdata = 32'h1234_5678; m_rsp_ready = 1'b0;
        m_req_valid = 1'b1; s_req_ready = 1'b1; m_req_addr = 32'h0000_0010;
        #2;
        chk(m_rsp_rdata == 32'h1234_5678, "R11 rdata identity", m_rsp_rdata, 32'h1234_5678);
        chk(m_req_ready == 1'b1, "R11 idle ready", 32'(m_req_ready), 32'd1);
        chk(s_req_valid == 1'b1, "R8 valid pass", 32'(s_req_valid), 32'd1);
        s_rsp_valid = 1'b0; s_req_ready = 1'b0; m_req_valid = 1'b0;

        // Combinational sweep, no acceptance (slave not ready)
        m_req_valid = 1'b1; m_req_write = 1'b1;
        for (int w = 0; w < 4; w++) begin
            for (int p = 0; p < 6; p++) begin
                for (int s = 0; s < 16; s++) begin
                    logic [31:0] a, d, ea;
                    a = (32'h4000_0000 * 32'(p % 4)) | (32'(w) << 16) | ((32'(p) * 32'h0000_0104 + 32'(s) * 4) & 32'h0000_FFFC);
                    d = (p == 0) ? 32'h1122_3344 : (32'h9E37_79B9 * 32'(p * 16 + s + 1));
                    ea = a & ~32'h0003_0000;
                    m_req_addr = a; m_req_wdata = d; m_req_wstrb = 4'(s);
                    m_req_write = s[0];
                    #1;
                    chk(s_req_addr == ea, "R6 address", s_req_addr, ea);
                    if (w == 0 || w == 3) chk(s_req_wdata == d, "R2 passthrough", s_req_wdata, d);
                    else if (w == 1) chk(s_req_wdata == exp_data(1, d), "R3 half", s_req_wdata, exp_data(1, d));
                    else chk(s_req_wdata == exp_data(2, d), "R4 byte", s_req_wdata, exp_data(2, d));
                    chk(s_req_wstrb == exp_strb(w, 4'(s)), "R5 strobe", 32'(s_req_wstrb), 32'(exp_strb(w, 4'(s))));
                    chk(win_err == (w == 3), "R1 window err", 32'(win_err), 32'(w == 3));
                    chk(s_req_write == s[0], "R8 write flag", 32'(s_req_write), 32'(s[0]));
                end
            end
        end
        m_req_valid = 1'b0;

        // Reads in each window, with a blocked second request
        for (int w = 0; w < 4; w++) begin
            for (int k = 0; k < 3; k++) begin
                logic [31:0] pat;
                pat = 32'hA1B2_C3D4 ^ (32'h0F1E_2D3C * 32'(k + w));
                accept_read(w, 32'h0000_0100 * 32'(k));
                @(negedge clk);
                s_rsp_valid = 1'b0;
                #2;
                chk(m_req_ready == 1'b0, "R9 ready held", 32'(m_req_ready), 32'd0);
                chk(s_req_valid == 1'b0, "R9 valid held", 32'(s_req_valid), 32'd0);
                @(negedge clk);
                m_req_valid = 1'b0;
                s_rsp_valid = 1'b1; s_rsp_rdata = pat; m_rsp_ready = 1'b1;
                #2;
                chk(m_rsp_valid == 1'b1, "R7 rsp valid", 32'(m_rsp_valid), 32'd1);
                chk(m_rsp_rdata == exp_data(w, pat), "R7 read permute", m_rsp_rdata, exp_data(w, pat));
                @(posedge clk);
                @(negedge clk);
                s_rsp_valid = 1'b0; m_rsp_ready = 1'b0;
            end
        end

        // R10: response and new request in the same cycle
        accept_read(2, 32'h0000_0040);
        @(negedge clk);
        m_req_addr = 32'h0001_0080;
        s_rsp_valid = 1'b1; s_rsp_rdata = 32'hDEAD_BEEF; m_rsp_ready = 1'b0;
        #2;
        chk(m_req_ready == 1'b0, "R10 stalled rsp blocks", 32'(m_req_ready), 32'd0);
        m_rsp_ready = 1'b1;
        #1;
        chk(m_req_ready == 1'b1, "R10 overlap accept", 32'(m_req_ready), 32'd1);
        chk(m_rsp_rdata == 32'hEFBE_ADDE, "R10 old mode", m_rsp_rdata, 32'hEFBE_ADDE);
        @(posedge clk);
        @(negedge clk);
        m_req_valid = 1'b0;
        s_rsp_rdata = 32'h0102_0304;
        #2;
        chk(m_rsp_rdata == 32'h0304_0102, "R10 new mode", m_rsp_rdata, 32'h0304_0102);
        @(posedge clk);
        @(negedge clk);
        s_rsp_valid = 1'b0; m_rsp_ready = 1'b0;
        #2;
        chk(m_req_ready == 1'b1 || s_req_ready == 1'b0, "R8 idle again", 32'(m_req_ready), 32'd1);

        done = 1;
        finish_sim();
    end
endmodule